// File: doc/BRIEF.md
# Bridge Exclusive-Access Lock Tracker

This block watches the transaction-start, lock and data-completion signals on both buses of a two-bus bridge. It keeps a separate record of the exclusive-access state of each bus. A locked sequence counts as started only under strict conditions. First, the bus must have been quiet in the previous cycle, with no transaction running and the lock line released. The lock line must also be low during the address phase and high in the very next cycle. The lock counts as held only once a data transfer completes under it.

A lock that the primary side places on a transaction the bridge forwards to the secondary side becomes a cross-bridge lock. While that lock lasts, the secondary bus is reported as locked. A locked attempt from the secondary side that the bridge would have to forward upward is never granted. Instead, the block asks for the transaction to be retried until that bus releases. The block does no arbitration and moves no data. All inputs are active high and sampled on one clock.

Top module: `bridge_lock_tracker`

## Requirements
- R1: After a synchronous active-low reset, whether it arrives idle or in the middle of a held lock, all four outputs are 0 in the first cycle after reset is released.
- R2: On either bus, a locked sequence starts as follows. In the cycle before the address phase, frame and lock were both 0. In the address phase (frame rises) lock is 0, and in the next cycle lock is 1. After this, the bus lock flag rises in the cycle after the first cycle in which done=1 while lock=1, and not earlier.
- R3: If lock is 1 during the address phase, the transaction is ordinary, and the lock flag stays 0 even when done=1 under lock.
- R4: If lock is still 0 in the cycle after the address phase, the transaction is ordinary, and the lock flag stays 0.
- R5: If lock was 1 in the cycle before the address phase (the bus was not quiet), the new transaction cannot start a lock.
- R6: A held lock survives cycles with frame=0 and lock=1. It is released in the cycle after frame and lock are both seen at 0, and the lock flag then reads 0.
- R7: The two buses keep independent lock state. Both can hold a lock at once, and releasing one leaves the other flag unchanged.
- R8: A primary lock whose address phase had pri_fwd=1 (the transaction is forwarded downstream) sets xbridge_lock=1 and forces sec_lock_held=1 until the primary lock is released, whatever the secondary bus does meanwhile.
- R9: A secondary locked sequence whose address phase had sec_fwd=1 (an upstream crossing) sets sec_retry=1 from the cycle after lock is confirmed. It never sets sec_lock_held, even on done=1, and sec_retry returns to 0 in the cycle after secondary frame and lock are both 0.
- R10: A non-locked upstream transaction (sec_fwd=1, lock never asserted) never raises sec_retry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| pri_frame | input | 1 | Primary transaction in progress; its rise marks the address phase |
| pri_lock | input | 1 | Primary lock line asserted |
| pri_done | input | 1 | Primary data transfer completed this cycle |
| pri_fwd | input | 1 | Primary transaction is claimed for forwarding downstream (valid in address phase) |
| sec_frame | input | 1 | Secondary transaction in progress; its rise marks the address phase |
| sec_lock | input | 1 | Secondary lock line asserted |
| sec_done | input | 1 | Secondary data transfer completed this cycle |
| sec_fwd | input | 1 | Secondary transaction is claimed for forwarding upstream (valid in address phase) |
| pri_lock_held | output | 1 | Primary bus lock established |
| sec_lock_held | output | 1 | Secondary bus locked, locally or by a cross-bridge lock |
| xbridge_lock | output | 1 | A downstream lock is held across the bridge |
| sec_retry | output | 1 | Upstream locked attempt refused; terminate with retry |

## Verification
Each bus tracker is a small state machine whose state reaches the outputs through no further register. A wrong state therefore shows on the lock-held, cross-lock or retry flags in the cycle right after the edge that entered it. The bench compares every one of those flags after every clock. A wrong quiet-bus record or a wrong captured forward flag stays hidden until the next address phase. For that reason the vector walk places each ordering case (lock too early, lock too late, lock already busy) directly after the cycle that sets it up.

// File: rtl/lkt_pkg.sv
// Shared types for the bridge lock tracker.
package lkt_pkg;

    // Per-bus lock sequencing state.
    typedef enum logic [2:0] {
        LK_IDLE = 3'd0,  // no transaction, or between transactions without a lock
        LK_ADDR = 3'd1,  // address phase seen with lock low; lock expected next
        LK_PEND = 3'd2,  // lock asserted; waiting for first completed transfer
        LK_HELD = 3'd3,  // lock established on this bus
        LK_BUSY = 3'd4   // ordinary (non-locked) transaction in progress
    } lk_state_e;

endpackage

// File: rtl/lkt_bus_tracker.sv
// Per-bus lock tracker.
// Follows one bus's frame/lock/done signals and decides whether a locked
// sequence has started correctly and when the lock becomes established.
// Assumes all inputs are synchronous to clk and active high. ALLOW_CROSS
// selects whether a lock on a transaction flagged for forwarding may be
// established (1) or must be refused (0).
module lkt_bus_tracker
    import lkt_pkg::*;
#(
    parameter bit ALLOW_CROSS = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame,
    input  logic lock,
    input  logic done,
    input  logic fwd,
    output logic held,
    output logic pend,
    output logic fwd_q
);

    lk_state_e state, state_nxt;
    logic      quiet_q;
    logic      bus_free;
    logic      may_hold;

    assign bus_free = !frame && !lock;
    assign may_hold = ALLOW_CROSS || !fwd_q;

    // Next-state decision for the lock sequence.
    always_comb begin
        state_nxt = state;
        unique case (state)
            LK_IDLE: if (frame) state_nxt = (quiet_q && !lock) ? LK_ADDR : LK_BUSY;
            LK_ADDR: state_nxt = lock ? LK_PEND : LK_BUSY;
            LK_PEND: begin
                if (bus_free)                    state_nxt = LK_IDLE;
                else if (done && lock && may_hold) state_nxt = LK_HELD;
            end
            LK_HELD: if (bus_free) state_nxt = LK_IDLE;
            LK_BUSY: if (bus_free) state_nxt = LK_IDLE;
            default: state_nxt = LK_IDLE;
        endcase
    end

    // State register, previous-cycle quiet record and forward capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= LK_IDLE;
            quiet_q <= 1'b1;
            fwd_q   <= 1'b0;
        end else begin
            state   <= state_nxt;
            quiet_q <= bus_free;
            if (state == LK_IDLE && frame) fwd_q <= fwd;
        end
    end

    assign held = (state == LK_HELD);
    assign pend = (state == LK_PEND);

    AST_HOLD_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(held) |-> $past(done && lock)); // R2

    AST_EARLY_LOCK_ORDINARY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LK_IDLE && frame && lock) |=> !held); // R3

    AST_RELEASE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (held && !frame && !lock) |=> !held); // R6

    generate
        if (!ALLOW_CROSS) begin : g_no_cross
            AST_UPSTREAM_NEVER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
                !(held && fwd_q)); // R9
        end
    endgenerate

endmodule

// File: rtl/lkt_cross.sv
// Cross-bridge lock combiner.
// Merges the two bus trackers into the block's outputs. A held primary lock
// on a forwarded transaction locks the secondary bus too. An upstream locked
// attempt waiting on the secondary side is turned into a retry request.
// Assumes the tracker outputs are registered state decodes.
module lkt_cross (
    input  logic clk,
    input  logic rst_n,
    input  logic pri_frame,
    input  logic pri_lock,
    input  logic pri_held,
    input  logic pri_fwd_q,
    input  logic sec_held,
    input  logic sec_pend,
    input  logic sec_fwd_q,
    output logic pri_lock_held,
    output logic sec_lock_held,
    output logic xbridge_lock,
    output logic sec_retry
);

    // Output decode from tracker state.
    always_comb begin
        xbridge_lock  = pri_held && pri_fwd_q;
        pri_lock_held = pri_held;
        sec_lock_held = sec_held || xbridge_lock;
        sec_retry     = sec_pend && sec_fwd_q;
    end

    AST_XLOCK_ENDS_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(xbridge_lock) |-> $past(!pri_frame && !pri_lock)); // R8

    AST_RETRY_NOT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        sec_retry |-> !sec_held); // R9

endmodule

// File: rtl/bridge_lock_tracker.sv
// Bridge exclusive-access lock tracker (top).
// Runs one tracker per bus. The primary tracker may establish forwarded
// locks; the secondary tracker refuses them. Both feed the cross combiner.
// Assumes a single clock domain for both buses' sampled signals.
module bridge_lock_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic pri_frame,
    input  logic pri_lock,
    input  logic pri_done,
    input  logic pri_fwd,
    input  logic sec_frame,
    input  logic sec_lock,
    input  logic sec_done,
    input  logic sec_fwd,
    output logic pri_lock_held,
    output logic sec_lock_held,
    output logic xbridge_lock,
    output logic sec_retry
);

    logic p_held, p_pend, p_fwd_q;
    logic s_held, s_pend, s_fwd_q;

    lkt_bus_tracker #(.ALLOW_CROSS(1'b1)) u_pri (
        .clk(clk), .rst_n(rst_n),
        .frame(pri_frame), .lock(pri_lock), .done(pri_done), .fwd(pri_fwd),
        .held(p_held), .pend(p_pend), .fwd_q(p_fwd_q)
    );

    lkt_bus_tracker #(.ALLOW_CROSS(1'b0)) u_sec (
        .clk(clk), .rst_n(rst_n),
        .frame(sec_frame), .lock(sec_lock), .done(sec_done), .fwd(sec_fwd),
        .held(s_held), .pend(s_pend), .fwd_q(s_fwd_q)
    );

    lkt_cross u_cross (
        .clk(clk), .rst_n(rst_n),
        .pri_frame(pri_frame), .pri_lock(pri_lock),
        .pri_held(p_held), .pri_fwd_q(p_fwd_q),
        .sec_held(s_held), .sec_pend(s_pend), .sec_fwd_q(s_fwd_q),
        .pri_lock_held(pri_lock_held), .sec_lock_held(sec_lock_held),
        .xbridge_lock(xbridge_lock), .sec_retry(sec_retry)
    );

    AST_PEND_UNUSED_OK: assert property (@(posedge clk) disable iff (!rst_n)
        p_pend |=> !(p_held && !$past(pri_done))); // R2

endmodule

// File: tb/tb_bridge_lock_tracker.sv
module tb_bridge_lock_tracker;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pri_frame = 1'b0, pri_lock = 1'b0, pri_done = 1'b0, pri_fwd = 1'b0;
    logic sec_frame = 1'b0, sec_lock = 1'b0, sec_done = 1'b0, sec_fwd = 1'b0;
    logic pri_lock_held, sec_lock_held, xbridge_lock, sec_retry;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    bridge_lock_tracker dut (
        .clk(clk), .rst_n(rst_n),
        .pri_frame(pri_frame), .pri_lock(pri_lock), .pri_done(pri_done), .pri_fwd(pri_fwd),
        .sec_frame(sec_frame), .sec_lock(sec_lock), .sec_done(sec_done), .sec_fwd(sec_fwd),
        .pri_lock_held(pri_lock_held), .sec_lock_held(sec_lock_held),
        .xbridge_lock(xbridge_lock), .sec_retry(sec_retry)
    );

    // Row: {req[3:0], pf,pl,pd,px, sf,sl,sd,sx, exp pri_held,sec_held,xlock,retry}
    localparam int NV = 36;
    localparam logic [15:0] VEC [NV] = '{
        16'b0001_0000_0000_0000, // R1 idle
        16'b0010_1000_0000_0000, // R2 address, lock low
        16'b0010_1100_0000_0000, // R2 lock one cycle later
        16'b0010_1110_0000_1000, // R2 done -> held
        16'b0110_0100_0000_1000, // R6 lock kept between transactions
        16'b0110_0000_0000_0000, // R6 release
        16'b0110_0000_0000_0000, // R6 idle
        16'b0011_1100_0000_0000, // R3 lock in address phase
        16'b0011_1110_0000_0000, // R3 done does not lock
        16'b0011_0000_0000_0000, // R3 idle
        16'b0100_1000_0000_0000, // R4 address
        16'b0100_1010_0000_0000, // R4 lock never asserted
        16'b0100_0000_0000_0000, // R4 idle
        16'b0101_0100_0000_0000, // R5 lock busy, bus idle
        16'b0101_1000_0000_0000, // R5 address while not quiet
        16'b0101_1110_0000_0000, // R5 no lock
        16'b0101_0000_0000_0000, // R5 idle
        16'b0111_1000_1000_0000, // R7 both address
        16'b0111_1100_1100_0000, // R7 both lock
        16'b0111_1110_1110_1100, // R7 both held
        16'b0111_0100_0000_1000, // R7 secondary released only
        16'b0111_0100_0000_1000, // R7 primary unaffected
        16'b0111_0000_0000_0000, // R7 primary released
        16'b1000_1001_0000_0000, // R8 forwarded address
        16'b1000_1100_0000_0000, // R8 lock
        16'b1000_1110_0000_1110, // R8 cross lock held
        16'b1000_0100_1000_1110, // R8 secondary traffic, still locked
        16'b1000_0100_1010_1110, // R8 secondary done, still locked
        16'b1000_0000_0000_0000, // R8 primary released
        16'b1001_0000_1001_0000, // R9 upstream address
        16'b1001_0000_1100_0001, // R9 lock -> retry
        16'b1001_0000_1110_0001, // R9 done ignored
        16'b1001_0000_0000_0000, // R9 released, retry drops
        16'b1010_0000_1001_0000, // R10 upstream ordinary
        16'b1010_0000_1000_0000, // R10 no lock
        16'b1010_0000_0000_0000  // R10 idle
    };

    task automatic chk(input int req, input logic [3:0] got, input logic [3:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL R%0d got %b expected %b", req, got, exp);
        end
    endtask

    task automatic drive(input logic [7:0] v);
        {pri_frame, pri_lock, pri_done, pri_fwd, sec_frame, sec_lock, sec_done, sec_fwd} = v;
    endtask

    function automatic logic [3:0] outs();
        return {pri_lock_held, sec_lock_held, xbridge_lock, sec_retry};
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk(1, outs(), 4'b0000); // R1 state right after reset

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][11:4]);
            @(negedge clk);
            chk(int'(VEC[i][15:12]), outs(), VEC[i][3:0]);
        end

        // R1: reset in the middle of a cross-bridge lock
        drive(8'b1001_0000); @(negedge clk);
        drive(8'b1100_0000); @(negedge clk);
        drive(8'b1110_0000); @(negedge clk);
        chk(8, outs(), 4'b1110); // R8 lock up before reset
        rst_n = 1'b0;
        drive(8'b0000_0000);
        @(negedge clk);
        rst_n = 1'b1;
        chk(1, outs(), 4'b0000); // R1
        @(negedge clk);
        chk(1, outs(), 4'b0000); // R1 stays clear

        // R9: upstream retry persists across frame drop while lock held
        drive(8'b0000_1001); @(negedge clk);
        drive(8'b0000_1100); @(negedge clk);
        chk(9, outs(), 4'b0001); // R9
        drive(8'b0000_0100); @(negedge clk);
        chk(9, outs(), 4'b0001); // R9 lock still high
        drive(8'b0000_0000); @(negedge clk);
        chk(9, outs(), 4'b0000); // R9 released

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule